// File: doc/BRIEF.md
# Three-C Cache Miss Classifier

This block watches a stream of line-granular read addresses and sorts every access by the cause of its miss. Three tag models run in lockstep on each access, and all three start empty. The first is the cache being evaluated, a set-associative tag store with LRU replacement. The second is a fully associative LRU tag store that has the same total number of entries. The third is a first-touch bitmap that stands in for a cache of unbounded size. Data, fills, writes and prefetch are not modelled. Only tags and classification are kept.

Every accepted access produces a result in the following cycle. The result says whether the access hit the cache under study. A miss is labelled compulsory, capacity or conflict. Running saturating counters total the accesses and each label. A signed net counter tracks how many more misses the set-associative cache took than the fully associative model. This counter can go negative, because LRU in a set-associative cache sometimes keeps a line that the fully associative model has already dropped.

Top module: `miss_classifier`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a clock edge that samples `acc_valid` high with `clr` low. In every other cycle `res_valid` and all four flags are low.
- R2: Whenever `res_valid` is high, exactly one of `res_hit`, `res_compulsory`, `res_capacity`, `res_conflict` is high.
- R3: `res_hit` reports a hit in the set-associative model. That model uses the low log2(SETS) bits of the line address as the set index and the remaining bits as the tag. It fills an invalid way before it evicts a valid one, and it evicts the least recently used way. Both hits and fills make the accessed way the most recent.
- R4: An access is compulsory when it is the first reference to its line since reset or clear. Such an access misses in both finite models.
- R5: An access is capacity when it misses in the set-associative model, is not a first reference, and also misses in the fully associative LRU model of WAYS*SETS entries.
- R6: An access is conflict when it misses in the set-associative model, is not a first reference, and hits in the fully associative model.
- R7: An access that hits in the set-associative model but misses in the fully associative one is reported as a hit.
- R8: `net_conflict` is a two's-complement count. It steps +1 when the set-associative model misses and the fully associative model hits. It steps -1 for the opposite case. Otherwise it holds, and it may become negative.
- R9: The counters `cnt_access`, `cnt_hit`, `cnt_compulsory`, `cnt_capacity` and `cnt_conflict` each add one per accepted access of their kind, and each holds at all-ones.
- R10: A high `clr` at a clock edge empties all three models, zeroes every counter, and ignores any access offered in that cycle.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all models and counters |
| acc_valid | input | 1 | Access offered this cycle |
| acc_line | input | LINE_W | Line address of the access |
| res_valid | output | 1 | Result of previous cycle's access |
| res_hit | output | 1 | Hit in the set-associative model |
| res_compulsory | output | 1 | First-reference miss |
| res_capacity | output | 1 | Miss in both finite models |
| res_conflict | output | 1 | Miss caused by set mapping only |
| cnt_access | output | CNT_W | Accepted accesses |
| cnt_hit | output | CNT_W | Hits |
| cnt_compulsory | output | CNT_W | Compulsory misses |
| cnt_capacity | output | CNT_W | Capacity misses |
| cnt_conflict | output | CNT_W | Conflict misses |
| net_conflict | output | CNT_W | Signed set-associative minus fully associative misses |

## Verification
The stimulus drives three line addresses into one set until a line that the fully associative model still holds has been evicted from that set. A design that confuses the two finite models marks that access capacity instead of conflict. It then touches more than WAYS*SETS distinct lines, so that revisits miss in the fully associative model. If the eviction order is wrong, those revisits come out as hit or conflict. Lines that stay resident in their own set but age out of the fully associative model must read as hits while `net_conflict` goes below zero. A sign or saturation error in that counter shows up there. Clear is tested with an access offered in the same cycle, and a re-touched line must then read as compulsory again.

// File: rtl/miss3c_pkg.sv
package miss3c_pkg;
  // Per-access classification, one-hot when a result is valid
  typedef struct packed {
    logic hit;
    logic compulsory;
    logic capacity;
    logic conflict;
  } cls_flags_t;

  // Index of each running counter
  typedef enum int {
    CNT_ACC  = 0,
    CNT_HIT  = 1,
    CNT_COMP = 2,
    CNT_CAP  = 3,
    CNT_CONF = 4
  } cnt_sel_e;

  localparam int NUM_CNT = 5;
endpackage

// File: rtl/lru_tag_store.sv
// Tag-only LRU store: NSET sets of WAYS ways, age rank 0 = most recent.
module lru_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lookup,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int NSET = 2 ** IDX_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic             valid_q [NSET][WAYS];
  logic             valid_d [NSET][WAYS];
  logic [AGE_W-1:0] age_q   [NSET][WAYS];
  logic [AGE_W-1:0] age_d   [NSET][WAYS];
  logic [TAG_W-1:0] tag_q   [NSET][WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [AGE_W-1:0] sel_way;
  logic [AGE_W-1:0] sel_age;
  logic             tag_we;

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
  end
  assign hit = |hit_vec;

  // Way choice: hitting way, else first invalid way, else oldest way
  always_comb begin : pick
    logic found;
    found   = 1'b0;
    sel_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && hit_vec[w]) begin
        sel_way = AGE_W'(w);
        found   = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && !valid_q[idx][w]) begin
        sel_way = AGE_W'(w);
        found   = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && age_q[idx][w] == AGE_MAX) begin
        sel_way = AGE_W'(w);
        found   = 1'b1;
      end
  end
  assign sel_age = age_q[idx][sel_way];
  assign tag_we  = lookup && !clr && !hit;

  always_comb begin
    valid_d = valid_q;
    age_d   = age_q;
    if (clr) begin
      for (int s = 0; s < NSET; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_d[s][w] = 1'b0;
          age_d[s][w]   = AGE_MAX;
        end
    end else if (lookup) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == sel_way) begin
          valid_d[idx][w] = 1'b1;
          age_d[idx][w]   = '0;
        end else if (age_q[idx][w] < sel_age) begin
          age_d[idx][w] = age_q[idx][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          age_q[s][w]   <= AGE_MAX;
        end
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[idx][sel_way] <= tag;
  end

  // R3: a line can sit in at most one way of its set
  p_single_way_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |-> $onehot0(hit_vec));

  // R3: a line just looked up is resident on the next access to it
  p_resident_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && !clr) ##1 (lookup && idx == $past(idx) && tag == $past(tag)) |-> hit);
endmodule

// File: rtl/first_touch.sv
// Bitmap of lines referenced since reset or clear.
module first_touch #(
  parameter int LINE_W = 8,
  localparam int LINES = 2 ** LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lookup,
  input  logic [LINE_W-1:0] line,
  output logic              seen
);
  logic [LINES-1:0] seen_q;
  logic [LINES-1:0] seen_d;

  assign seen = seen_q[line];

  always_comb begin
    seen_d = seen_q;
    if (clr)         seen_d = '0;
    else if (lookup) seen_d[line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  // R4: once touched, a line stays marked until clear
  p_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && !clr) |=> seen_q[$past(line)]);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                cnt_d = '0;
    else if (inc && ~&cnt)  cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R9: a full counter never wraps
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt && !clr) |=> &cnt);
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import miss3c_pkg::*;
#(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int LINE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_compulsory,
  output logic              res_capacity,
  output logic              res_conflict,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_compulsory,
  output logic [CNT_W-1:0]  cnt_capacity,
  output logic [CNT_W-1:0]  cnt_conflict,
  output logic [CNT_W-1:0]  net_conflict
);
  localparam int SA_IDX_BITS = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int SA_IDX_W    = (SETS > 1) ? SA_IDX_BITS : 1;
  localparam int SA_TAG_W    = LINE_W - SA_IDX_BITS;
  localparam int FA_ENTRIES  = WAYS * SETS;

  logic                acc_go;
  logic                sa_hit, fa_hit, seen;
  logic [SA_IDX_W-1:0] sa_idx;
  cls_flags_t          cls_d, cls_q;
  logic                valid_q;
  logic [CNT_W-1:0]    net_d, net_q;
  logic [NUM_CNT-1:0]  cnt_inc;
  logic [CNT_W-1:0]    cnt_val [NUM_CNT];

  assign acc_go = acc_valid && !clr;

  generate
    if (SETS > 1) begin : g_idx
      assign sa_idx = acc_line[SA_IDX_BITS-1:0];
    end else begin : g_noidx
      assign sa_idx = '0;
    end
  endgenerate

  lru_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(SA_TAG_W)) i_sa (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lookup(acc_go),
    .idx(sa_idx), .tag(acc_line[LINE_W-1:SA_IDX_BITS]), .hit(sa_hit));

  lru_tag_store #(.SETS(1), .WAYS(FA_ENTRIES), .TAG_W(LINE_W)) i_fa (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lookup(acc_go),
    .idx(1'b0), .tag(acc_line), .hit(fa_hit));

  first_touch #(.LINE_W(LINE_W)) i_ft (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lookup(acc_go),
    .line(acc_line), .seen(seen));

  always_comb begin
    cls_d            = '0;
    cls_d.hit        = acc_go && sa_hit;
    cls_d.compulsory = acc_go && !sa_hit && !seen;
    cls_d.capacity   = acc_go && !sa_hit && seen && !fa_hit;
    cls_d.conflict   = acc_go && !sa_hit && seen && fa_hit;
  end

  always_comb begin
    net_d = net_q;
    if (clr)                          net_d = '0;
    else if (acc_go && !sa_hit && fa_hit) net_d = net_q + 1'b1;
    else if (acc_go && sa_hit && !fa_hit) net_d = net_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cls_q   <= '0;
      net_q   <= '0;
    end else begin
      valid_q <= acc_go;
      cls_q   <= cls_d;
      net_q   <= net_d;
    end
  end

  assign cnt_inc[CNT_ACC]  = acc_go;
  assign cnt_inc[CNT_HIT]  = cls_d.hit;
  assign cnt_inc[CNT_COMP] = cls_d.compulsory;
  assign cnt_inc[CNT_CAP]  = cls_d.capacity;
  assign cnt_inc[CNT_CONF] = cls_d.conflict;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      sat_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .inc(cnt_inc[g]), .cnt(cnt_val[g]));
    end
  endgenerate

  assign res_valid      = valid_q;
  assign res_hit        = cls_q.hit;
  assign res_compulsory = cls_q.compulsory;
  assign res_capacity   = cls_q.capacity;
  assign res_conflict   = cls_q.conflict;
  assign cnt_access     = cnt_val[CNT_ACC];
  assign cnt_hit        = cnt_val[CNT_HIT];
  assign cnt_compulsory = cnt_val[CNT_COMP];
  assign cnt_capacity   = cnt_val[CNT_CAP];
  assign cnt_conflict   = cnt_val[CNT_CONF];
  assign net_conflict   = net_q;

  // R1: every accepted access yields a result next cycle
  p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !clr) |=> res_valid);

  // R1: no access, no result and no flags
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !clr) |=> (!res_valid && cls_q == '0));

  // R2: exactly one label per result
  p_one_label_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(cls_q) == 1));

  // R4: a first reference misses in both finite models
  p_first_misses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && !seen) |-> (!sa_hit && !fa_hit));

  // R8: net counter moves by at most one per cycle
  p_net_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (net_q == $past(net_q) || net_q == $past(net_q) + 1'b1 ||
              net_q == $past(net_q) - 1'b1));

  // R10: clear empties counters
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (net_q == '0 && cnt_val[CNT_ACC] == '0 && !res_valid));
endmodule

// File: tb/test_miss_classifier.sv
`timescale 1ns/1ps
module test_miss_classifier;
  localparam int CNT_W = 32;
  localparam int NVEC  = 20;
  // {line[7:0], class[1:0] (0 hit,1 compulsory,2 capacity,3 conflict), net[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h00, 2'd1, 8'd0},   {8'h04, 2'd1, 8'd0},   {8'h00, 2'd0, 8'd0},
    {8'h08, 2'd1, 8'd0},   {8'h04, 2'd3, 8'd1},   {8'h00, 2'd3, 8'd2},
    {8'h01, 2'd1, 8'd2},   {8'h02, 2'd1, 8'd2},   {8'h03, 2'd1, 8'd2},
    {8'h05, 2'd1, 8'd2},   {8'h06, 2'd1, 8'd2},   {8'h07, 2'd1, 8'd2},
    {8'h08, 2'd2, 8'd2},   {8'h00, 2'd0, 8'd2},   {8'h04, 2'd2, 8'd2},
    {8'h01, 2'd0, 8'd1},   {8'h02, 2'd0, 8'd0},   {8'h03, 2'd0, 8'hFF},
    {8'hFF, 2'd1, 8'hFF},  {8'h07, 2'd3, 8'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n, clr, acc_valid;
  logic [7:0]       acc_line;
  logic             res_valid, res_hit, res_compulsory, res_capacity, res_conflict;
  logic [CNT_W-1:0] cnt_access, cnt_hit, cnt_compulsory, cnt_capacity, cnt_conflict;
  logic [CNT_W-1:0] net_conflict;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  miss_classifier i_miss_classifier (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_line(acc_line),
    .res_valid(res_valid), .res_hit(res_hit), .res_compulsory(res_compulsory),
    .res_capacity(res_capacity), .res_conflict(res_conflict),
    .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_compulsory(cnt_compulsory),
    .cnt_capacity(cnt_capacity), .cnt_conflict(cnt_conflict),
    .net_conflict(net_conflict));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] flags_of(input logic [1:0] c);
    case (c)
      2'd0:    return 4'b1000;
      2'd1:    return 4'b0100;
      2'd2:    return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk_counts(input string req, input longint a, input longint h,
                            input longint cp, input longint cy, input longint cf, input longint n);
    chk(req, "cnt_access", cnt_access, a);
    chk(req, "cnt_hit", cnt_hit, h);
    chk(req, "cnt_compulsory", cnt_compulsory, cp);
    chk(req, "cnt_capacity", cnt_capacity, cy);
    chk(req, "cnt_conflict", cnt_conflict, cf);
    chk(req, "net_conflict", longint'($signed(net_conflict)), n);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; acc_valid = 1'b0; acc_line = '0;
    repeat (3) @(negedge clk);
    // R11: outputs idle in reset
    chk("R11", "res_valid", res_valid, 0);
    chk_counts("R11", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "res_valid idle", res_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      acc_valid = 1'b1;
      acc_line  = VEC[i][17:10];
      @(negedge clk);
      chk("R1", "res_valid", res_valid, 1);
      chk(req_of(VEC[i][9:8]), $sformatf("flags line %0h", VEC[i][17:10]),
          {res_hit, res_compulsory, res_capacity, res_conflict}, flags_of(VEC[i][9:8]));
      chk(($signed(VEC[i][7:0]) < 0) ? "R7" : "R8", "net_conflict",
          longint'($signed(net_conflict)), longint'($signed(VEC[i][7:0])));
    end
    acc_valid = 1'b0;
    @(negedge clk);
    chk("R1", "res_valid after stop", res_valid, 0);
    chk("R2", "flags after stop", {res_hit, res_compulsory, res_capacity, res_conflict}, 0);
    // R9: totals 20 accesses, 5 hits, 10 compulsory, 2 capacity, 3 conflict
    chk_counts("R9", 20, 5, 10, 2, 3, 0);
    @(negedge clk);
    chk_counts("R9", 20, 5, 10, 2, 3, 0);

    // R10: clear with an access offered in the same cycle
    clr = 1'b1; acc_valid = 1'b1; acc_line = 8'h00;
    @(negedge clk);
    chk("R10", "res_valid on clear", res_valid, 0);
    chk_counts("R10", 0, 0, 0, 0, 0, 0);
    clr = 1'b0;
    @(negedge clk);
    chk("R10", "line 00 compulsory after clear",
        {res_hit, res_compulsory, res_capacity, res_conflict}, 4'b0100);
    acc_line = 8'h07;
    @(negedge clk);
    chk("R10", "line 07 compulsory after clear",
        {res_hit, res_compulsory, res_capacity, res_conflict}, 4'b0100);
    acc_line = 8'h00;
    @(negedge clk);
    chk("R3", "line 00 hit after refill",
        {res_hit, res_compulsory, res_capacity, res_conflict}, 4'b1000);
    acc_valid = 1'b0;
    @(negedge clk);
    chk_counts("R10", 3, 1, 2, 0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule